// File: doc/BRIEF.md
# Banked GPIO Set/Clear Register File

This block holds the configuration state of a 28-pin general-purpose I/O controller and samples the pins. The pins are split into two banks. The lower bank holds pins 0 to 15 and sits at offset 0x00. The upper bank holds pins 16 to 27 and sits 0x80 higher. Every bank register is 16 bits of per-pin state behind a 32-bit access word.

A write never needs a read-modify-write. A 1 in data bit n asks for the bank's pin n to be set, and a 1 in data bit n+16 asks for it to be cleared. Zero bits leave their pins alone. Software drives a pin by enabling its output driver and then setting or clearing its level. It makes a pin an input by setting its input-enable bit.

Reads are combinational on the address. They return the bank's bits in data positions 0 to 15. The per-pin register bits are brought straight out as pad controls. The input path goes through a two-stage synchronizer and is seen through a read-only read-back register.

Top module: `gpio_setclr_regs`

## Requirements
- R1: After reset, every feature register is 0, so all pad control outputs are 0 and every register reads 0.
- R2: A write with data bit n (0..15) at 1 and bit n+16 at 0 sets pin n of the addressed bank and feature.
- R3: A write with data bit n+16 at 1 and bit n at 0 clears pin n of the addressed bank and feature.
- R4: Pins whose set and clear bits are both 0 in a write keep their value. Every register keeps its value in cycles with no write.
- R5: A write that requests both set and clear for the same pin leaves that pin unchanged.
- R6: Address bit 7 selects the bank. Offsets in the range 0x00..0x7F reach pins 0..15, and the same offsets plus 0x80 reach pins 16..27 at bit positions 0..11.
- R7: A read returns the addressed bank's bits in data bits 0..15, and data bits 16..31 always read 0.
- R8: In the upper bank, bit positions 12..15 always read 0, and writes to them have no effect.
- R9: The read-back register (offset 0x30) returns each pin's level ANDed with its input-enable bit. The level is seen through two flops, so a pin change shows on a read after the second rising edge and not after the first.
- R10: Bank offsets map to pad outputs as follows: 0x00 drives pin_out, 0x04 drives pin_oe, 0x08 drives pin_od, 0x18 drives pin_pu, 0x1C drives pin_pd, and 0x20 drives pin_ie.
- R11: Writes to the read-back offset or to any unmapped offset change no register, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, applied at the rising edge |
| addr | input | 8 | Byte address; bit 7 selects the bank |
| wdata | input | 32 | Write data: low half sets, high half clears |
| rdata | output | 32 | Combinational read data for addr |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output level per pin |
| pin_oe | output | 28 | Output driver enable per pin |
| pin_od | output | 28 | Open-drain mode per pin |
| pin_pu | output | 28 | Pull-up enable per pin |
| pin_pd | output | 28 | Pull-down enable per pin |
| pin_ie | output | 28 | Input enable per pin |

## Verification
The assertions assume that wr_en, addr and wdata are settled before each rising edge and carry no unknown bits while rst_n is high. The bench meets this by changing these inputs only one nanosecond after an edge. The read-back gating check assumes that a change on pin_in reaches the read path only through the synchronizer. The bench therefore changes the pins only in steps it controls, and it holds them steady while it takes each timing sample.

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs #(
  parameter int NPINS   = 28,
  parameter int LO_PINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_od,
  output logic [NPINS-1:0] pin_pu,
  output logic [NPINS-1:0] pin_pd,
  output logic [NPINS-1:0] pin_ie
);
  localparam int HALF    = LO_PINS;
  localparam int HI_PINS = NPINS - LO_PINS;
  localparam int NFEAT   = 6;
  localparam logic [2:0] F_IE = 3'd5;

  logic [NPINS-1:0] feat [NFEAT];
  logic [NPINS-1:0] sync1, sync2;
  logic [NPINS-1:0] set_v, clr_v, src;
  logic [2:0]       feat_sel;
  logic             feat_hit, rb_hit;
  logic             bank_hi;
  logic [HALF-1:0]  bank_val;

  assign bank_hi = addr[7];

  always_comb begin
    feat_hit = 1'b1;
    feat_sel = 3'd0;
    case (addr[6:0])
      7'h00:   feat_sel = 3'd0;
      7'h04:   feat_sel = 3'd1;
      7'h08:   feat_sel = 3'd2;
      7'h18:   feat_sel = 3'd3;
      7'h1C:   feat_sel = 3'd4;
      7'h20:   feat_sel = F_IE;
      default: feat_hit = 1'b0;
    endcase
  end

  assign rb_hit = (addr[6:0] == 7'h30);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int  BITN = (p >= LO_PINS) ? p - LO_PINS : p;
    localparam logic IN_HI = (p >= LO_PINS);
    assign set_v[p] = wr_en && feat_hit && (bank_hi == IN_HI) &&  wdata[BITN] && !wdata[BITN+HALF];
    assign clr_v[p] = wr_en && feat_hit && (bank_hi == IN_HI) && !wdata[BITN] &&  wdata[BITN+HALF];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NFEAT; i++) begin
      if (!rst_n)
        feat[i] <= '0;
      else if (feat_hit && feat_sel == 3'(i))
        feat[i] <= (feat[i] | set_v) & ~clr_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    if (rb_hit)        src = sync2 & feat[F_IE];
    else if (feat_hit) src = feat[feat_sel];
    else               src = '0;
    if (bank_hi) bank_val = {{(HALF-HI_PINS){1'b0}}, src[NPINS-1:LO_PINS]};
    else         bank_val = src[HALF-1:0];
  end

  assign rdata   = {{(32-HALF){1'b0}}, bank_val};
  assign pin_out = feat[0];
  assign pin_oe  = feat[1];
  assign pin_od  = feat[2];
  assign pin_pu  = feat[3];
  assign pin_pd  = feat[4];
  assign pin_ie  = feat[F_IE];

  AST_SET_LO_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h00 && wdata[0] && !wdata[16]) |=> pin_out[0]);  // R2
  AST_CLR_OE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h04 && wdata[16] && !wdata[0]) |=> !pin_oe[0]);  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_od)
                && $stable(pin_pu) && $stable(pin_pd) && $stable(pin_ie)));  // R4
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h80 && wdata[0] && wdata[16]) |=> $stable(pin_out[LO_PINS]));  // R5
  AST_RB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h30 && !pin_ie[0]) |-> !rdata[0]);  // R9
  AST_RB_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[6:0] == 7'h30) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_ie)));  // R11
endmodule

// File: tb/gpio_setclr_regs_tb.sv
module gpio_setclr_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [27:0] pin_in = '0;
  logic [27:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd, pin_ie;

  always #2 clk = ~clk;

  gpio_setclr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd), .pin_ie(pin_ie)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return rdata;
      1: return {4'b0, pin_out};
      2: return {4'b0, pin_oe};
      3: return {4'b0, pin_od};
      4: return {4'b0, pin_pu};
      5: return {4'b0, pin_pd};
      default: return {4'b0, pin_ie};
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = pick(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a;
    q.push_back('{0, e, tag});
  endtask

  task automatic chk(input int sel, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    q.push_back('{sel, e, tag});
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int s = 1; s <= 6; s++) chk(s, 32'h0, "R1 reset port");
    rd(8'h00, 32'h0, "R1 reset read lo");
    rd(8'hA0, 32'h0, "R1 reset read hi");
    // R2 set
    wr(8'h00, 32'h0000_A5A5);
    chk(1, 32'h0000_A5A5, "R2 set pin_out");
    rd(8'h00, 32'h0000_A5A5, "R2 read");
    // R4 zero bits keep
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0000_A5A7, "R4 zeros hold");
    // R3 clear
    wr(8'h00, 32'h0021_0000);
    rd(8'h00, 32'h0000_A586, "R3 clear");
    // R5 both requested
    wr(8'h00, 32'h000C_000C);
    rd(8'h00, 32'h0000_A586, "R5 both hold");
    // R6 high bank
    wr(8'h80, 32'h0000_0FFF);
    chk(1, 32'h0FFF_A586, "R6 hi bank pins");
    rd(8'h80, 32'h0000_0FFF, "R6 hi read");
    // R8 nonexistent high pins
    wr(8'h84, 32'h0000_F001);
    chk(2, 32'h0001_0000, "R8 hi oe");
    rd(8'h84, 32'h0000_0001, "R8 hi pad bits");
    wr(8'h80, 32'hF000_0000);
    rd(8'h80, 32'h0000_0FFF, "R8 hi clear pad bits");
    // R10 feature offsets
    wr(8'h08, 32'h0000_0001);
    wr(8'h18, 32'h0000_0002);
    wr(8'h1C, 32'h0000_0004);
    wr(8'h20, 32'h0000_0008);
    chk(3, 32'h0000_0001, "R10 od");
    chk(4, 32'h0000_0002, "R10 pu");
    chk(5, 32'h0000_0004, "R10 pd");
    chk(6, 32'h0000_0008, "R10 ie");
    chk(1, 32'h0FFF_A586, "R10 out untouched");
    // R11 unmapped and read-only writes
    wr(8'h0C, 32'h0000_FFFF);
    wr(8'h30, 32'h0000_FFFF);
    wr(8'hB0, 32'hFFFF_FFFF);
    chk(1, 32'h0FFF_A586, "R11 out held");
    chk(2, 32'h0001_0000, "R11 oe held");
    chk(6, 32'h0000_0008, "R11 ie held");
    rd(8'h0C, 32'h0, "R11 unmapped read");
    // R9 read-back through two flops
    @(posedge clk); #1;
    pin_in = 28'hFFF_FFFF;
    addr = 8'h30;
    q.push_back('{0, 32'h0, "R9 before edge"});
    rd(8'h30, 32'h0, "R9 one edge");
    rd(8'h30, 32'h0000_0008, "R9 two edges");
    rd(8'hB0, 32'h0, "R9 hi gated");
    wr(8'hA0, 32'h0000_0003);
    rd(8'hB0, 32'h0000_0003, "R9 hi enabled");
    // R7 upper half zero with full high bank
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h30, 32'h0000_FFFF, "R7 upper half zero");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule